// File: doc/BRIEF.md
# Bulk OUT Endpoint Receive Controller

This block owns the receive side of a single bulk OUT endpoint of a USB device. The packet side delivers bytes that have already been error checked. Each packet is framed by a start marker and an end marker, and the end marker carries a good/bad verdict. For every good packet the block chooses a handshake (ACK, NAK or STALL). Accepted packets go into one of two 64-byte ping-pong buffers.

Software works through a 32-bit control/status word and a byte-read port. The status word shows:

| Bit | Meaning |
|-----|---------|
| 7 | short packet held (latched) |
| 6 | FIFO not empty (live) |
| 5 | force stall (read/write) |
| 4 | stall sent (write 1 to clear) |
| 3 | DMA mode (read/write) |
| 2 | reserved |
| 1 | packet complete (write 1 to clear) |
| 0 | packet waiting for service (live) |

Bits 31:8 and bit 2 always read 0.

The receive interrupt follows the packet-complete flag. In DMA mode it is also held back until fewer than half a packet of bytes remain in the FIFO. The DMA engine uses this to drain the FIFO before the processor is told.

Top module: `bulk_out_rx`

## Requirements
- R1: After a synchronous reset, bits 7:0 of `csr_rdata` are 0, `rx_irq` is 0 and `hs_valid` is 0.
- R2: A packet that starts while at least one buffer is free and ends with `pkt_good`=1 is stored. `hs_valid` pulses for one cycle with `hs_code`=1 (ACK) in the cycle after `pkt_eop`. In that same cycle packet-complete (bit 1) and service (bit 0) read 1. `fifo_rdata` then presents the stored bytes in arrival order, and each `fifo_rd` pulse advances it by one byte.
- R3: A zero-length packet (start then end, no bytes) is acknowledged and occupies a buffer. It sets bit 0 with bit 6 = 0. A single `fifo_rd` while it is at the head frees that buffer.
- R4: Bit 0 stays 1 until every byte of every stored packet has been read. A buffer is freed by the read that takes its last byte. Bit 6 is 1 exactly while any stored byte remains unread.
- R5: A packet that starts while both buffers hold unread packets is answered with `hs_code`=2 (NAK). Its bytes are discarded and no status bit changes.
- R6: Bit 7 is loaded when a packet is stored while bit 1 is 0. It is loaded with 1 if the packet is shorter than 64 bytes. It keeps its value while bit 1 stays set and returns to 0 when bit 1 is cleared.
- R7: Bits 1 and 4 clear only when a write carries 1 in that position; a 0 leaves them unchanged. A set event in the same cycle as a clearing write leaves the bit at 1.
- R8: When bit 5 is 1 as a packet starts, the good packet gets `hs_code`=3 (STALL) and nothing is stored. Bit 4 sets in the same cycle the STALL handshake appears.
- R9: A packet ending with `pkt_good`=0 produces no handshake. It stores nothing and changes no status bit.
- R10: `rx_irq` = `rx_irq_en` AND bit 1 AND (bit 3 = 0 OR fewer than 32 unread bytes remain).
- R11: Bits 5 and 3 read back the last value written. Bits 31:8 and bit 2 read 0 whatever is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_sop | input | 1 | Start of an OUT data packet (no byte this cycle) |
| pkt_byte_valid | input | 1 | `pkt_byte` carries a data byte |
| pkt_byte | input | 8 | Received data byte |
| pkt_eop | input | 1 | End of packet (no byte this cycle) |
| pkt_good | input | 1 | Packet passed error checking, valid with `pkt_eop` |
| hs_valid | output | 1 | Handshake choice valid (one-cycle pulse) |
| hs_code | output | 2 | 1 = ACK, 2 = NAK, 3 = STALL |
| csr_wr | input | 1 | Write strobe for the control/status word |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Control/status word |
| fifo_rd | input | 1 | Consume the presented byte |
| fifo_rdata | output | 8 | Byte at the head of the FIFO |
| rx_irq_en | input | 1 | Receive interrupt enable |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The bench builds the controller with its default 64-byte maximum packet size, which makes the DMA threshold 32 bytes. With these values a full-size packet, a short packet queued behind it, and the NAK for a third packet are all reachable in a few hundred cycles. The threshold can be crossed in both directions by reading part of a 69-byte backlog. The same settings allow a clearing write to land on the exact end-of-packet cycle, and a zero-length packet to sit in one buffer while the other fills.

// File: rtl/bo_rx_pkg.sv
package bo_rx_pkg;

    typedef enum logic [1:0] {
        HS_NONE  = 2'd0,
        HS_ACK   = 2'd1,
        HS_NAK   = 2'd2,
        HS_STALL = 2'd3
    } hs_e;

    typedef enum logic [1:0] {
        PM_IDLE,
        PM_STORE,
        PM_NAK,
        PM_STALL
    } pmode_e;

    // Low byte of the control/status word, most significant field first.
    typedef struct packed {
        logic short_pkt;
        logic not_empty;
        logic force_stall;
        logic stall_sent;
        logic dma_mode;
        logic rsvd;
        logic pkt_done;
        logic service;
    } csr_view_t;

    localparam int WB_PKT_DONE   = 1;
    localparam int WB_DMA_MODE   = 3;
    localparam int WB_STALL_SENT = 4;
    localparam int WB_FORCE      = 5;

    function automatic hs_e mode_to_hs(pmode_e m);
        case (m)
            PM_STORE: return HS_ACK;
            PM_NAK:   return HS_NAK;
            PM_STALL: return HS_STALL;
            default:  return HS_NONE;
        endcase
    endfunction

endpackage

// File: rtl/bo_rx_pkt_ctl.sv
module bo_rx_pkt_ctl
    import bo_rx_pkg::*;
#(
    parameter int MAX_PKT = 64,
    parameter int AW      = $clog2(MAX_PKT),
    parameter int CNT_W   = $clog2(MAX_PKT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sop,
    input  logic             byte_v,
    input  logic             eop,
    input  logic             good,
    input  logic             force_stall,
    input  logic             bufs_full,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic             commit,
    output logic [CNT_W-1:0] commit_len,
    output logic             stall_sent,
    output logic             hs_valid,
    output hs_e              hs_code
);

    pmode_e           mode_q;
    logic [CNT_W-1:0] cnt_q;
    logic             room;
    logic             answer;

    assign room       = cnt_q < CNT_W'(MAX_PKT);
    assign wr_en      = byte_v && (mode_q == PM_STORE) && room;
    assign wr_addr    = cnt_q[AW-1:0];
    assign answer     = eop && good && (mode_q != PM_IDLE);
    assign commit     = answer && (mode_q == PM_STORE);
    assign commit_len = cnt_q;
    assign stall_sent = answer && (mode_q == PM_STALL);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= PM_IDLE;
            cnt_q    <= '0;
            hs_valid <= 1'b0;
            hs_code  <= HS_NONE;
        end else begin
            hs_valid <= answer;
            hs_code  <= answer ? mode_to_hs(mode_q) : HS_NONE;
            if (sop) begin
                cnt_q  <= '0;
                mode_q <= force_stall ? PM_STALL : (bufs_full ? PM_NAK : PM_STORE);
            end else begin
                if (wr_en) cnt_q <= cnt_q + CNT_W'(1);
                if (eop) mode_q <= PM_IDLE;
            end
        end
    end

endmodule

// File: rtl/bo_rx_buffers.sv
module bo_rx_buffers #(
    parameter int MAX_PKT = 64,
    parameter int AW      = $clog2(MAX_PKT),
    parameter int CNT_W   = $clog2(MAX_PKT + 1),
    parameter int BL_W    = $clog2(2 * MAX_PKT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [7:0]       wr_data,
    input  logic             commit,
    input  logic [CNT_W-1:0] commit_len,
    input  logic             rd_en,
    output logic [7:0]       rd_data,
    output logic             bufs_full,
    output logic             any_pkt,
    output logic [BL_W-1:0]  bytes_left
);

    logic [7:0]       mem [2][MAX_PKT];
    logic [CNT_W-1:0] len_q [2];
    logic [CNT_W-1:0] rem [2];
    logic [1:0]       vld_q;
    logic             head_q, tail_q;
    logic [AW-1:0]    rptr_q;
    logic             last_of_head;

    for (genvar b = 0; b < 2; b++) begin : g_buf
        assign rem[b] = vld_q[b]
            ? (len_q[b] - ((head_q == 1'(b)) ? CNT_W'(rptr_q) : '0))
            : '0;
    end

    assign bytes_left   = BL_W'(rem[0]) + BL_W'(rem[1]);
    assign bufs_full    = &vld_q;
    assign any_pkt      = |vld_q;
    assign rd_data      = mem[head_q][rptr_q];
    assign last_of_head = (len_q[head_q] == '0) ||
                          (CNT_W'(rptr_q) + CNT_W'(1) >= len_q[head_q]);

    always_ff @(posedge clk) begin
        if (wr_en) mem[tail_q][wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= '0;
            head_q <= 1'b0;
            tail_q <= 1'b0;
            rptr_q <= '0;
            len_q  <= '{default: '0};
        end else begin
            if (commit) begin
                vld_q[tail_q] <= 1'b1;
                len_q[tail_q] <= commit_len;
                tail_q        <= ~tail_q;
            end
            if (rd_en && vld_q[head_q]) begin
                if (last_of_head) begin
                    vld_q[head_q] <= 1'b0;
                    head_q        <= ~head_q;
                    rptr_q        <= '0;
                end else begin
                    rptr_q <= rptr_q + AW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/bo_rx_csr.sv
module bo_rx_csr
    import bo_rx_pkg::*;
#(
    parameter int THRESH = 32,
    parameter int BL_W   = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            csr_wr,
    input  logic [31:0]     csr_wdata,
    input  logic            commit,
    input  logic            short_pkt,
    input  logic            stall_sent,
    input  logic            any_pkt,
    input  logic [BL_W-1:0] bytes_left,
    input  logic            irq_en,
    output logic [31:0]     csr_rdata,
    output logic            force_stall,
    output logic            irq
);

    logic      dma_q, sst_q, done_q, short_q;
    logic      done_clr, sst_clr;
    csr_view_t view;

    assign done_clr = csr_wr && csr_wdata[WB_PKT_DONE];
    assign sst_clr  = csr_wr && csr_wdata[WB_STALL_SENT];

    always_ff @(posedge clk) begin
        if (rst) begin
            force_stall <= 1'b0;
            dma_q       <= 1'b0;
            sst_q       <= 1'b0;
            done_q      <= 1'b0;
            short_q     <= 1'b0;
        end else begin
            if (csr_wr) begin
                force_stall <= csr_wdata[WB_FORCE];
                dma_q       <= csr_wdata[WB_DMA_MODE];
            end
            done_q <= commit || (done_q && !done_clr);
            sst_q  <= stall_sent || (sst_q && !sst_clr);
            if (commit && !done_q) short_q <= short_pkt;
            else if (done_clr && !commit) short_q <= 1'b0;
        end
    end

    always_comb begin
        view             = '0;
        view.short_pkt   = short_q;
        view.not_empty   = (bytes_left != '0);
        view.force_stall = force_stall;
        view.stall_sent  = sst_q;
        view.dma_mode    = dma_q;
        view.pkt_done    = done_q;
        view.service     = any_pkt;
    end

    assign csr_rdata = {24'd0, view};
    assign irq = irq_en && done_q && (!dma_q || (bytes_left < BL_W'(THRESH)));

endmodule

// File: rtl/bulk_out_rx.sv
module bulk_out_rx
    import bo_rx_pkg::*;
#(
    parameter int MAX_PKT = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pkt_sop,
    input  logic        pkt_byte_valid,
    input  logic [7:0]  pkt_byte,
    input  logic        pkt_eop,
    input  logic        pkt_good,
    output logic        hs_valid,
    output logic [1:0]  hs_code,
    input  logic        csr_wr,
    input  logic [31:0] csr_wdata,
    output logic [31:0] csr_rdata,
    input  logic        fifo_rd,
    output logic [7:0]  fifo_rdata,
    input  logic        rx_irq_en,
    output logic        rx_irq
);

    localparam int AW     = $clog2(MAX_PKT);
    localparam int CNT_W  = $clog2(MAX_PKT + 1);
    localparam int BL_W   = $clog2(2 * MAX_PKT + 1);
    localparam int THRESH = MAX_PKT / 2;

    logic             wr_en, commit, stall_sent, force_stall;
    logic             bufs_full, any_pkt;
    logic [AW-1:0]    wr_addr;
    logic [CNT_W-1:0] commit_len;
    logic [BL_W-1:0]  bytes_left;
    hs_e              hs_q;

    bo_rx_pkt_ctl #(.MAX_PKT(MAX_PKT), .AW(AW), .CNT_W(CNT_W)) u_pkt (
        .clk(clk), .rst(rst),
        .sop(pkt_sop), .byte_v(pkt_byte_valid), .eop(pkt_eop), .good(pkt_good),
        .force_stall(force_stall), .bufs_full(bufs_full),
        .wr_en(wr_en), .wr_addr(wr_addr),
        .commit(commit), .commit_len(commit_len), .stall_sent(stall_sent),
        .hs_valid(hs_valid), .hs_code(hs_q)
    );

    bo_rx_buffers #(.MAX_PKT(MAX_PKT), .AW(AW), .CNT_W(CNT_W), .BL_W(BL_W)) u_buf (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(pkt_byte),
        .commit(commit), .commit_len(commit_len),
        .rd_en(fifo_rd), .rd_data(fifo_rdata),
        .bufs_full(bufs_full), .any_pkt(any_pkt), .bytes_left(bytes_left)
    );

    bo_rx_csr #(.THRESH(THRESH), .BL_W(BL_W)) u_csr (
        .clk(clk), .rst(rst),
        .csr_wr(csr_wr), .csr_wdata(csr_wdata),
        .commit(commit), .short_pkt(commit_len < CNT_W'(MAX_PKT)),
        .stall_sent(stall_sent), .any_pkt(any_pkt), .bytes_left(bytes_left),
        .irq_en(rx_irq_en),
        .csr_rdata(csr_rdata), .force_stall(force_stall), .irq(rx_irq)
    );

    assign hs_code = hs_q;

endmodule

// File: rtl/bo_rx_checker.sv
module bo_rx_checker (
    input logic        clk,
    input logic        rst,
    input logic        pkt_eop,
    input logic        pkt_good,
    input logic        hs_valid,
    input logic [1:0]  hs_code,
    input logic        csr_wr,
    input logic [31:0] csr_wdata,
    input logic [31:0] csr_rdata,
    input logic        rx_irq_en,
    input logic        rx_irq
);

    assert_hs_follows_eop_R2: assert property (@(posedge clk) disable iff (rst)
        hs_valid |-> $past(pkt_eop) && $past(pkt_good));

    assert_bad_pkt_silent_R9: assert property (@(posedge clk) disable iff (rst)
        (pkt_eop && !pkt_good) |=> !hs_valid);

    assert_done_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (csr_rdata[1] && !(csr_wr && csr_wdata[1])) |=> csr_rdata[1]);

    assert_sst_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (csr_rdata[4] && !(csr_wr && csr_wdata[4])) |=> csr_rdata[4]);

    assert_stall_flags_R8: assert property (@(posedge clk) disable iff (rst)
        (hs_valid && hs_code == 2'd3) |-> csr_rdata[4]);

    assert_ack_sets_done_R2: assert property (@(posedge clk) disable iff (rst)
        (hs_valid && hs_code == 2'd1) |-> (csr_rdata[1] && csr_rdata[0]));

    assert_bytes_imply_service_R4: assert property (@(posedge clk) disable iff (rst)
        csr_rdata[6] |-> csr_rdata[0]);

    assert_irq_gate_R10: assert property (@(posedge clk) disable iff (rst)
        rx_irq |-> (rx_irq_en && csr_rdata[1]));

endmodule

bind bulk_out_rx bo_rx_checker u_chk (
    .clk(clk), .rst(rst), .pkt_eop(pkt_eop), .pkt_good(pkt_good),
    .hs_valid(hs_valid), .hs_code(hs_code), .csr_wr(csr_wr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .rx_irq_en(rx_irq_en), .rx_irq(rx_irq)
);

// File: tb/tb_bulk_out_rx.sv
module tb_bulk_out_rx;

    localparam int MAXP = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pkt_sop = 0, pkt_byte_valid = 0, pkt_eop = 0, pkt_good = 0;
    logic [7:0]  pkt_byte = '0;
    logic        hs_valid;
    logic [1:0]  hs_code;
    logic        csr_wr = 0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        fifo_rd = 0;
    logic [7:0]  fifo_rdata;
    logic        rx_irq_en = 0;
    logic        rx_irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    bulk_out_rx #(.MAX_PKT(MAXP)) dut (
        .clk(clk), .rst(rst),
        .pkt_sop(pkt_sop), .pkt_byte_valid(pkt_byte_valid), .pkt_byte(pkt_byte),
        .pkt_eop(pkt_eop), .pkt_good(pkt_good),
        .hs_valid(hs_valid), .hs_code(hs_code),
        .csr_wr(csr_wr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .fifo_rd(fifo_rd), .fifo_rdata(fifo_rdata),
        .rx_irq_en(rx_irq_en), .rx_irq(rx_irq)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model, updated once per edge and compared mid-phase.
    bit         m_fst, m_dme, m_sst, m_rpc, m_rsp, m_hsv;
    int         m_mode, m_hsc;
    int         lens[$];
    logic [7:0] data[$];
    logic [7:0] cur[$];

    always begin : model
        bit o_fst, o_rpc, rpc_set, rpc_clr, sst_set, sst_clr, do_commit;
        logic [7:0] exp_csr;
        bit exp_irq;
        @(posedge clk);
        #3;
        if (rst) begin
            m_fst = 0; m_dme = 0; m_sst = 0; m_rpc = 0; m_rsp = 0; m_hsv = 0;
            m_mode = 0; m_hsc = 0;
            lens.delete(); data.delete(); cur.delete();
        end else begin
            o_fst = m_fst; o_rpc = m_rpc;
            rpc_set = 0; sst_set = 0; do_commit = 0;
            rpc_clr = csr_wr && csr_wdata[1];
            sst_clr = csr_wr && csr_wdata[4];
            m_hsv = 0;
            if (pkt_sop) begin
                m_mode = o_fst ? 3 : (lens.size() == 2 ? 2 : 1);
                cur.delete();
            end else begin
                if (pkt_byte_valid && m_mode == 1 && cur.size() < MAXP) cur.push_back(pkt_byte);
                if (pkt_eop) begin
                    if (pkt_good && m_mode != 0) begin
                        m_hsv = 1; m_hsc = m_mode;
                        if (m_mode == 3) sst_set = 1;
                        if (m_mode == 1) do_commit = 1;
                    end
                    m_mode = 0;
                end
            end
            if (fifo_rd && lens.size() > 0) begin
                if (lens[0] > 0) begin
                    void'(data.pop_front());
                    lens[0] = lens[0] - 1;
                    if (lens[0] == 0) void'(lens.pop_front());
                end else begin
                    void'(lens.pop_front());
                end
            end
            if (do_commit) begin
                lens.push_back(cur.size());
                foreach (cur[i]) data.push_back(cur[i]);
                rpc_set = 1;
            end
            if (rpc_set && !o_rpc) m_rsp = (cur.size() < MAXP);
            else if (rpc_clr && !rpc_set) m_rsp = 0;
            m_rpc = rpc_set | (o_rpc & !rpc_clr);
            m_sst = sst_set | (m_sst & !sst_clr);
            if (csr_wr) begin
                m_fst = csr_wdata[5];
                m_dme = csr_wdata[3];
            end
        end
        exp_csr = {m_rsp, data.size() != 0, m_fst, m_sst, m_dme, 1'b0, m_rpc, lens.size() != 0};
        exp_irq = rx_irq_en && m_rpc && (!m_dme || data.size() < MAXP / 2);
        chk(csr_rdata[7] == exp_csr[7], "R6 short-packet flag", csr_rdata[7], exp_csr[7]);
        chk(csr_rdata[6] == exp_csr[6], "R4 not-empty flag", csr_rdata[6], exp_csr[6]);
        chk(csr_rdata[5] == exp_csr[5] && csr_rdata[3] == exp_csr[3], "R11 rw bits",
            {csr_rdata[5], csr_rdata[3]}, {exp_csr[5], exp_csr[3]});
        chk(csr_rdata[4] == exp_csr[4], "R8 R7 stall-sent flag", csr_rdata[4], exp_csr[4]);
        chk(csr_rdata[1] == exp_csr[1], "R2 R7 R9 packet-complete flag", csr_rdata[1], exp_csr[1]);
        chk(csr_rdata[0] == exp_csr[0], "R3 R4 service flag", csr_rdata[0], exp_csr[0]);
        chk(csr_rdata[31:8] == 0 && csr_rdata[2] == 0, "R11 reserved bits",
            {csr_rdata[31:8], csr_rdata[2]}, 0);
        chk(rx_irq == exp_irq, "R10 interrupt", rx_irq, exp_irq);
        chk(hs_valid == m_hsv && (!m_hsv || hs_code == 2'(m_hsc)), "R2 R5 R8 R9 handshake",
            {hs_valid, hs_code}, {m_hsv, 2'(m_hsc)});
        if (lens.size() > 0 && lens[0] > 0)
            chk(fifo_rdata == data[0], "R2 read data", fifo_rdata, data[0]);
    end

    task automatic send_pkt(input int len, input bit good, input int seed);
        pkt_sop = 1;
        @(negedge clk);
        pkt_sop = 0;
        for (int i = 0; i < len; i++) begin
            pkt_byte_valid = 1;
            pkt_byte = 8'(seed + i * 7);
            @(negedge clk);
        end
        pkt_byte_valid = 0;
        pkt_eop = 1;
        pkt_good = good;
        @(negedge clk);
        pkt_eop = 0;
        pkt_good = 0;
        @(negedge clk);
    endtask

    task automatic csr_write(input logic [31:0] w);
        csr_wr = 1;
        csr_wdata = w;
        @(negedge clk);
        csr_wr = 0;
    endtask

    task automatic read_n(input int n);
        for (int i = 0; i < n; i++) begin
            fifo_rd = 1;
            @(negedge clk);
        end
        fifo_rd = 0;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(csr_rdata[7:0] == 0 && !rx_irq && !hs_valid, "R1 reset state",
            {csr_rdata[7:0], rx_irq, hs_valid}, 0);
        rx_irq_en = 1;

        // R2/R6: short packet stored and read back
        send_pkt(10, 1, 8'h11);
        chk(csr_rdata[7] == 1, "R6 short latched", csr_rdata[7], 1);
        read_n(10);
        chk(csr_rdata[0] == 0, "R4 service drops after drain", csr_rdata[0], 0);
        csr_write(32'h2);

        // R3: zero-length packet
        send_pkt(0, 1, 0);
        chk(csr_rdata[0] == 1 && csr_rdata[6] == 0, "R3 zero-length held",
            {csr_rdata[0], csr_rdata[6]}, 2'b10);
        read_n(1);
        chk(csr_rdata[0] == 0, "R3 zero-length released", csr_rdata[0], 0);
        csr_write(32'h2);

        // R5/R6/R10: fill both buffers, third is NAKed, DMA gating
        send_pkt(64, 1, 8'h40);
        send_pkt(5, 1, 8'h90);
        chk(csr_rdata[7] == 0, "R6 held while complete set", csr_rdata[7], 0);
        send_pkt(9, 1, 8'hA0);
        csr_write(32'h0);
        chk(csr_rdata[1] == 1, "R7 write of zero ignored", csr_rdata[1], 1);
        csr_write(32'h8);
        chk(rx_irq == 0, "R10 irq held in DMA mode", rx_irq, 0);
        read_n(40);
        chk(rx_irq == 1, "R10 irq below threshold", rx_irq, 1);
        read_n(29);

        // R9: bad packet leaves everything alone
        send_pkt(7, 0, 8'h33);

        // R7: clears during incoming packets
        fork
            send_pkt(20, 1, 8'h55);
            begin repeat (5) @(negedge clk); csr_write(32'hA); end
        join
        fork
            send_pkt(12, 1, 8'h66);
            begin repeat (13) @(negedge clk); csr_write(32'hA); end
        join
        chk(csr_rdata[1] == 1, "R7 set wins over clear", csr_rdata[1], 1);
        read_n(32);

        // R8: forced stall
        csr_write(32'h20);
        send_pkt(3, 1, 8'h77);
        chk(csr_rdata[4] == 1, "R8 stall sent", csr_rdata[4], 1);
        fork
            send_pkt(4, 1, 8'h78);
            begin repeat (5) @(negedge clk); csr_write(32'h30); end
        join
        csr_write(32'hFFFF_FFFF);
        chk(csr_rdata[31:8] == 0 && csr_rdata[2] == 0, "R11 reserved ignore writes",
            csr_rdata, 32'h0);
        csr_write(32'h0);
        send_pkt(64, 1, 8'h01);
        read_n(64);
        repeat (4) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule